// File: doc/BRIEF.md
# PWM Output Conditioning and Interrupt Aggregator

This block sits between a bank of PWM channel generators and the output pins. Each channel's raw waveform passes through two inversion stages, each set by its own register, and then through a third XOR with a per-pin output latch bit. The XOR with the latch applies only while the module and that pin's direction are both enabled. When a pin is not enabled, it shows its latch value and the waveform does not reach it. Because the stages are plain XORs, setting two of them cancels the inversion.

The block also collects one event pulse from each channel into a sticky per-channel flag. From these events it forms a single common interrupt request. That request is raised only when the common enable and the channel's own select bit are both set. Neither the channel flags nor the common request clear on acknowledge. Software clears them with write-one-to-clear writes. An event that arrives in the same cycle as a clear wins over the clear.

Software programs the block through a simple write port. It has a 3-bit address and a data word that is one bit per channel wide.

Top module: `pwm_out_cond`

## Requirements
- R1: Each of the four channels drives only its own pin. `pin_o[i]` depends only on `pwm_i[i]` and on bit i of the configuration registers.
- R2: Register 0 is the polarity register. While pin i is enabled, bit i = 0 passes `pwm_i[i]` unchanged and bit i = 1 inverts it.
- R3: Register 1 is the port-inversion register. Setting bit i inverts pin i again. With both the polarity bit and the port-inversion bit set, an enabled pin shows the non-inverted waveform.
- R4: Register 2 is the output latch. While pin i is enabled, latch bit i = 1 inverts the pin and latch bit i = 0 leaves it unchanged.
- R5: Pin i is enabled when control register 4 bit 0 (module enable) is 1 and direction register 3 bit i is 1. A disabled pin equals latch bit i. `pin_oe_o` equals the direction register.
- R6: After reset, every register, channel flag and the common request are zero, so `pin_o`, `pin_oe_o`, `ch_flag_o` and `irq_o` are all 0.
- R7: A pulse on `evt_i[i]` sets `ch_flag_o[i]` from the next cycle on. The flag stays set until software writes 1 to bit i of register 6.
- R8: When an event on channel i arrives in the same cycle as a clear write to register 6 for bit i, the flag stays set.
- R9: The common request is set only by an event on a channel whose select bit in register 5 is 1, and only while control register 4 bit 1 (common enable) is 1. A flag that was raised while the gates were closed does not raise the request when the gates open later.
- R10: `irq_o` rises in the cycle after the enabled event. A pulse on `ack_i` does not change it.
- R11: The common request is cleared only by writing 1 to bit 0 of register 7. An enabled event in the same cycle as that clear, or in any later cycle, sets the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 4 | Raw PWM waveforms, one per channel |
| evt_i | input | 4 | Channel event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 4 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge strobe (no effect on state) |
| pin_o | output | 4 | Conditioned pin values |
| pin_oe_o | output | 4 | Per-pin output direction |
| ch_flag_o | output | 4 | Sticky channel request flags |
| irq_o | output | 1 | Common interrupt request |

## Verification
The assertions assume that `evt_i` and the write port change only between rising edges. They also assume that a clear write and an event may meet in the same cycle, since that is the ordering the flag logic has to resolve. The bench drives every input on the falling edge. It holds each event for exactly one cycle and deliberately stacks event pulses onto clear writes, so that the set-wins rule is exercised at the port. The polarity sweep covers every combination of waveform, polarity, port inversion, latch, direction and module enable on every channel, with a different combination on each channel in each step.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_POL  = 3'd0,
        REG_PINV = 3'd1,
        REG_LAT  = 3'd2,
        REG_DIR  = 3'd3,
        REG_CTL  = 3'd4,
        REG_SEL  = 3'd5,
        REG_FCLR = 3'd6,
        REG_CCLR = 3'd7
    } reg_addr_e;

    localparam int CTL_MEN_BIT = 0;
    localparam int CTL_CIE_BIT = 1;

endpackage

// File: rtl/pwm_oc_cfg.sv
module pwm_oc_cfg
    import pwm_oc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NCH-1:0]    wr_data_i,
    output logic [NCH-1:0]    pol_o,
    output logic [NCH-1:0]    pinv_o,
    output logic [NCH-1:0]    latch_o,
    output logic [NCH-1:0]    dir_o,
    output logic [NCH-1:0]    sel_o,
    output logic              men_o,
    output logic              cie_o,
    output logic [NCH-1:0]    clr_flags_o,
    output logic              clr_common_o
);

    typedef struct packed {
        logic [NCH-1:0] pol;
        logic [NCH-1:0] pinv;
        logic [NCH-1:0] latch;
        logic [NCH-1:0] dir;
        logic [NCH-1:0] sel;
        logic           men;
        logic           cie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d        = cfg_q;
        clr_flags_o  = '0;
        clr_common_o = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                REG_POL:  cfg_d.pol   = wr_data_i;
                REG_PINV: cfg_d.pinv  = wr_data_i;
                REG_LAT:  cfg_d.latch = wr_data_i;
                REG_DIR:  cfg_d.dir   = wr_data_i;
                REG_CTL: begin
                    cfg_d.men = wr_data_i[CTL_MEN_BIT];
                    cfg_d.cie = wr_data_i[CTL_CIE_BIT];
                end
                REG_SEL:  cfg_d.sel   = wr_data_i;
                REG_FCLR: clr_flags_o  = wr_data_i;
                REG_CCLR: clr_common_o = wr_data_i[0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pol_o   = cfg_q.pol;
    assign pinv_o  = cfg_q.pinv;
    assign latch_o = cfg_q.latch;
    assign dir_o   = cfg_q.dir;
    assign sel_o   = cfg_q.sel;
    assign men_o   = cfg_q.men;
    assign cie_o   = cfg_q.cie;

    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == REG_POL) |=> $stable(pol_o)); // R2

endmodule

// File: rtl/pwm_oc_pol_chain.sv
module pwm_oc_pol_chain #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] pwm_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] pinv_i,
    input  logic [NCH-1:0] latch_i,
    input  logic [NCH-1:0] dir_i,
    input  logic           men_i,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] oe_o
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic stage_pol;
        logic stage_port;
        logic drive_en;

        always_comb begin
            stage_pol  = pwm_i[ch] ^ pol_i[ch];
            stage_port = stage_pol ^ pinv_i[ch];
            drive_en   = men_i & dir_i[ch];
            pin_o[ch]  = drive_en ? (stage_port ^ latch_i[ch]) : latch_i[ch];
        end
    end

    assign oe_o = dir_i;

endmodule

// File: rtl/pwm_oc_irq.sv
module pwm_oc_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic [NCH-1:0] sel_i,
    input  logic           cie_i,
    input  logic [NCH-1:0] clr_flags_i,
    input  logic           clr_common_i,
    input  logic           ack_i,
    output logic [NCH-1:0] flags_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [NCH-1:0] flags;
        logic           common;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       gated_evt;

    always_comb begin
        gated_evt     = cie_i && ((evt_i & sel_i) != '0);
        st_d.flags    = (st_q.flags & ~clr_flags_i) | evt_i;
        st_d.common   = (st_q.common & ~clr_common_i) | gated_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = st_q.common;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~clr_flags_i) != '0) |=>
        ((flags_o & $past(flags_o & ~clr_flags_i)) == $past(flags_o & ~clr_flags_i))); // R7

    AST_COMMON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(cie_i && ((evt_i & sel_i) != '0))); // R9

    AST_ACK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i && !clr_common_i) |=> irq_o); // R10

    AST_COMMON_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cie_i && ((evt_i & sel_i) != '0)) |=> irq_o); // R11

endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
    import pwm_oc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pwm_i,
    input  logic [NCH-1:0]    evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NCH-1:0]    wr_data_i,
    input  logic              ack_i,
    output logic [NCH-1:0]    pin_o,
    output logic [NCH-1:0]    pin_oe_o,
    output logic [NCH-1:0]    ch_flag_o,
    output logic              irq_o
);

    logic [NCH-1:0] pol, pinv, latch, dir, sel, clr_flags;
    logic           men, cie, clr_common;

    pwm_oc_cfg #(.NCH(NCH)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .pol_o        (pol),
        .pinv_o       (pinv),
        .latch_o      (latch),
        .dir_o        (dir),
        .sel_o        (sel),
        .men_o        (men),
        .cie_o        (cie),
        .clr_flags_o  (clr_flags),
        .clr_common_o (clr_common)
    );

    pwm_oc_pol_chain #(.NCH(NCH)) u_pol (
        .pwm_i   (pwm_i),
        .pol_i   (pol),
        .pinv_i  (pinv),
        .latch_i (latch),
        .dir_i   (dir),
        .men_i   (men),
        .pin_o   (pin_o),
        .oe_o    (pin_oe_o)
    );

    pwm_oc_irq #(.NCH(NCH)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .sel_i        (sel),
        .cie_i        (cie),
        .clr_flags_i  (clr_flags),
        .clr_common_i (clr_common),
        .ack_i        (ack_i),
        .flags_o      (ch_flag_o),
        .irq_o        (irq_o)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_PIN_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
            (men && dir[ch] && pol[ch] && pinv[ch] && !latch[ch]) |-> (pin_o[ch] == pwm_i[ch])); // R3

        AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(men && dir[ch]) |-> (pin_o[ch] == latch[ch])); // R5
    end

endmodule

// File: tb/tb_pwm_out_cond.sv
module tb_pwm_out_cond;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm_i = '0;
    logic [NCH-1:0] evt_i = '0;
    logic           wr_en_i = 1'b0;
    logic [2:0]     wr_addr_i = '0;
    logic [NCH-1:0] wr_data_i = '0;
    logic           ack_i = 1'b0;
    logic [NCH-1:0] pin_o, pin_oe_o, ch_flag_o;
    logic           irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    pwm_out_cond #(.NCH(NCH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_i     (pwm_i),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ack_i     (ack_i),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe_o),
        .ch_flag_o (ch_flag_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk("R6 pin", pin_o, 0);
        chk("R6 oe", pin_oe_o, 0);
        chk("R6 flags", ch_flag_o, 0);
        chk("R6 irq", irq_o, 0);

        // R1 R2 R3 R4 R5 sweep: men x 32 combos, channels offset
        for (int men = 0; men < 2; men++) begin
            for (int k = 0; k < 32; k++) begin
                logic [NCH-1:0] vp, vpol, vinv, vlat, vdir;
                for (int ch = 0; ch < NCH; ch++) begin
                    int c;
                    c = (k + 8 * ch + 3 * ch * ch) % 32;
                    vp[ch]   = c[0];
                    vpol[ch] = c[1];
                    vinv[ch] = c[2];
                    vlat[ch] = c[3];
                    vdir[ch] = c[4];
                end
                wr(3'd0, vpol);
                wr(3'd1, vinv);
                wr(3'd2, vlat);
                wr(3'd3, vdir);
                wr(3'd4, NCH'(men));
                pwm_i = vp;
                @(negedge clk);
                for (int ch = 0; ch < NCH; ch++) begin
                    logic e;
                    logic x;
                    x = (men == 1 && vdir[ch]) ? (vp[ch] ^ vpol[ch] ^ vinv[ch] ^ vlat[ch]) : vlat[ch];
                    e = x;
                    chk("R1 R2 R3 R4 R5 pin", {31'd0, pin_o[ch]}, {31'd0, e});
                end
                chk("R5 oe", pin_oe_o, vdir);
            end
        end

        // R9 event with common enable off
        wr(3'd4, 4'b0000);
        wr(3'd5, 4'b1111);
        pulse(4'b0001);
        chk("R7 flag set", ch_flag_o, 4'b0001);
        chk("R9 no irq gate closed", irq_o, 0);
        wr(3'd4, 4'b0010);
        @(negedge clk);
        chk("R9 no late irq", irq_o, 0);
        wr(3'd5, 4'b0010);
        pulse(4'b0001);
        chk("R9 unselected channel", irq_o, 0);
        pulse(4'b0010);
        chk("R10 irq next cycle", irq_o, 1);
        chk("R7 flags accumulate", ch_flag_o, 4'b0011);
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
        @(negedge clk);
        chk("R10 ack no effect", irq_o, 1);
        wr(3'd7, 4'b0001);
        chk("R11 common cleared", irq_o, 0);
        chk("R7 flags sticky", ch_flag_o, 4'b0011);
        wr(3'd6, 4'b0001);
        chk("R7 w1c", ch_flag_o, 4'b0010);

        // R8 clear and event together
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd6; wr_data_i = 4'b0010; evt_i = 4'b0010;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0;
        chk("R8 set wins", ch_flag_o, 4'b0010);
        chk("R11 rearm", irq_o, 1);

        // R11 common clear and event together
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd7; wr_data_i = 4'b0001; evt_i = 4'b0010;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0;
        chk("R11 set wins over clear", irq_o, 1);
        wr(3'd7, 4'b0001);
        chk("R11 clear", irq_o, 0);
        pulse(4'b0010);
        chk("R11 rearm after clear", irq_o, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule